// File: doc/BRIEF.md
# Clock-Fanout Enable Controller with Two-Wire Block-Transfer Slave

This block controls a bank of thirteen gated clock outputs. A two-wire serial slave on the standard open-drain bus writes and reads it. SCL and SDA are sampled on a faster system clock. Each line passes through a two-stage synchronizer and a short glitch filter. The slave then recognises bus START and STOP conditions and answers to one fixed 7-bit device address, 1101001.

A host write uses a block format. After the address byte (0xD2) come two header bytes: a command byte and a length byte. The slave acknowledges both and keeps neither. The data bytes after them land in control bytes 0, 1 and 2 in that order.

A host read (address byte 0xD3) first returns a fixed length byte, 0x09. It then returns the control bytes from byte 0 upward. There is no random addressing. Each stored bit either enables one clock output or is a spare bit that is only stored. Every enabled output carries the input reference clock through a plain AND gate.

Top module: `clkfan_ctrl`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits are 1101001 (0xD2 write, 0xD3 read). For any other address it leaves SDA released in the acknowledge slot and ignores the rest of that transfer.
- R2: In a write, the slave acknowledges the first two bytes after the address and discards them. The following data bytes are stored into control bytes 0, 1 and 2 in order.
- R3: In a read, the first byte returned is 0x09. Control bytes 0, 1, 2 follow, and every byte beyond them reads as 0xFF.
- R4: After reset, all 24 stored bits are 1, all thirteen output enables are 1, and SDA is released.
- R5: The enable mapping is as follows. Byte 0 bits 3..0 drive outputs 3..0, and byte 0 bits 7..6 drive outputs 5..4. Byte 1 bits 1..0 drive outputs 7..6, and byte 1 bits 7..4 drive outputs 11..8. Byte 2 bit 6 drives output 12. A 1 enables an output.
- R6: Each clock output equals the reference clock ANDed with that output's enable.
- R7: The slave acknowledges every byte of an addressed write. Data bytes beyond byte 2 change nothing.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and stays idle until the next START.
- R9: A START or STOP at any point, including inside a byte, aborts the current byte. A START begins a new transfer with an address byte, and a partial byte is never stored.
- R10: Spare bits (byte 0 bits 5..4, byte 1 bits 3..2, byte 2 bits 7 and 5..0) are stored and read back exactly as written.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| ref_clk | input | 1 | Reference clock to fan out |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| out_en | output | 13 | Per-output enable, bit i for output i |
| clk_out | output | 13 | Gated copies of ref_clk |

## Verification
The serial state is internal, but a wrong value shows up at the ports within the next byte. A wrong bit count or header count shifts stored data, and out_en shows this as soon as the write ends. A wrong read pointer returns the wrong sequence of bytes, starting with the first byte after the address. Acknowledge faults appear on SDA in the ninth clock of a byte. A missed START or STOP leaves the slave acknowledging an address it should reject, or storing a partial byte, and this appears in the very next transfer.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int NUM_OUTS = 13;
    localparam int NUM_REGS = 3;
    localparam int IDXW     = 4;

    localparam logic [6:0] DEV_ADDR   = 7'b1101001;
    localparam logic [7:0] COUNT_BYTE = 8'h09;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_RX,
        BS_RXACK,
        BS_TX,
        BS_TXACK
    } bus_state_e;

    typedef struct packed {
        logic            is_rd;
        logic [1:0]      hdr;
        logic [IDXW-1:0] idx;
    } xfer_t;

    typedef struct packed {
        logic            we;
        logic [IDXW-1:0] idx;
        logic [7:0]      data;
    } wr_req_t;

    function automatic logic [NUM_OUTS-1:0] map_enables(input logic [NUM_REGS*8-1:0] bank);
        logic [7:0] b0, b1, b2;
        b0 = bank[7:0];
        b1 = bank[15:8];
        b2 = bank[23:16];
        return {b2[6], b1[7:4], b1[1:0], b0[7:6], b0[3:0]};
    endfunction

endpackage

// File: rtl/clkfan_sync.sv
module clkfan_sync #(
    parameter int W           = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic [SYNC_STAGES-1:0] stg;
        logic [CW-1:0]          run;
        logic                   lvl;

        always_ff @(posedge clk) begin
            if (rst) begin
                stg <= '1;
                run <= '0;
                lvl <= 1'b1;
            end else begin
                stg <= {stg[SYNC_STAGES-2:0], raw[g]};
                if (stg[SYNC_STAGES-1] == lvl) begin
                    run <= '0;
                end else if (run == CW'(FILT_LEN - 1)) begin
                    run <= '0;
                    lvl <= stg[SYNC_STAGES-1];
                end else begin
                    run <= run + CW'(1);
                end
            end
        end

        assign clean[g] = lvl;
    end

endmodule

// File: rtl/clkfan_serial.sv
module clkfan_serial
    import clkfan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_f,
    input  logic            sda_f,
    input  logic [7:0]      rd_data,
    output logic [IDXW-1:0] rd_idx,
    output wr_req_t         wr,
    output logic            sda_oe
);
    localparam logic [IDXW-1:0] NREG_I = IDXW'(NUM_REGS);

    bus_state_e st;
    xfer_t      x;
    logic [3:0] cnt;
    logic [7:0] sr;
    logic       scl_q, sda_q, mack;
    logic       rise, fall, start_c, stop_c;
    logic [7:0] next_tx;

    assign rise    = scl_f & ~scl_q;
    assign fall    = ~scl_f & scl_q;
    assign start_c = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c  = scl_f & scl_q & ~sda_q & sda_f;
    assign next_tx = (x.hdr == 2'd0) ? COUNT_BYTE : rd_data;
    assign rd_idx  = x.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= BS_IDLE;
            x      <= '0;
            cnt    <= '0;
            sr     <= '0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            mack   <= 1'b0;
            wr     <= '0;
            sda_oe <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            wr.we <= 1'b0;
            if (start_c) begin
                st     <= BS_ADDR;
                x      <= '0;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                st     <= BS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    BS_ADDR, BS_RX: begin
                        if (rise) begin
                            sr  <= {sr[6:0], sda_f};
                            cnt <= cnt + 4'd1;
                        end else if (fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (st == BS_ADDR) begin
                                if (sr[7:1] == DEV_ADDR) begin
                                    sda_oe  <= 1'b1;
                                    x.is_rd <= sr[0];
                                    st      <= BS_RXACK;
                                end else begin
                                    st <= BS_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                st     <= BS_RXACK;
                                if (x.hdr != 2'd2) begin
                                    x.hdr <= x.hdr + 2'd1;
                                end else begin
                                    if (x.idx < NREG_I) begin
                                        wr <= '{we: 1'b1, idx: x.idx, data: sr};
                                    end
                                    if (x.idx != '1) x.idx <= x.idx + IDXW'(1);
                                end
                            end
                        end
                    end
                    BS_RXACK: begin
                        if (fall) begin
                            if (x.is_rd) begin
                                sr     <= next_tx;
                                sda_oe <= ~next_tx[7];
                                cnt    <= '0;
                                st     <= BS_TX;
                                if (x.hdr == 2'd0) x.hdr <= 2'd1;
                                else if (x.idx != '1) x.idx <= x.idx + IDXW'(1);
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= BS_RX;
                            end
                        end
                    end
                    BS_TX: begin
                        if (fall) begin
                            if (cnt == 4'd7) begin
                                st     <= BS_TXACK;
                                sda_oe <= 1'b0;
                            end else begin
                                sr     <= {sr[6:0], 1'b0};
                                sda_oe <= ~sr[6];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    BS_TXACK: begin
                        if (rise) begin
                            mack <= ~sda_f;
                        end else if (fall) begin
                            if (mack) begin
                                sr     <= next_tx;
                                sda_oe <= ~next_tx[7];
                                cnt    <= '0;
                                st     <= BS_TX;
                                if (x.hdr == 2'd0) x.hdr <= 2'd1;
                                else if (x.idx != '1) x.idx <= x.idx + IDXW'(1);
                            end else begin
                                st <= BS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: drive on SDA only moves while SCL is low
    p_oe_moves_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f);

    // R8: host NACK ends the read with SDA released
    p_nack_release_r8: assert property (@(posedge clk) disable iff (rst)
        (st == BS_TXACK && fall && !mack && !start_c && !stop_c) |=> (st == BS_IDLE && !sda_oe));

    // R1: a foreign address is never acknowledged
    p_foreign_addr_nack_r1: assert property (@(posedge clk) disable iff (rst)
        (st == BS_ADDR && fall && cnt == 4'd8 && sr[7:1] != DEV_ADDR) |=> !sda_oe);

endmodule

// File: rtl/clkfan_regs.sv
module clkfan_regs
    import clkfan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  wr_req_t             wr,
    input  logic [IDXW-1:0]     rd_idx,
    output logic [7:0]          rd_data,
    output logic [NUM_OUTS-1:0] en
);
    logic [NUM_REGS*8-1:0] bank;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[r*8 +: 8] <= 8'hFF;
            end else if (wr.we && wr.idx == IDXW'(r)) begin
                bank[r*8 +: 8] <= wr.data;
            end
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDXW'(i)) rd_data = bank[i*8 +: 8];
        end
    end

    assign en = map_enables(bank);

    // R4: every output is enabled right after reset
    p_reset_all_on_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&en));

    // R2: a write to byte 0 shows up on outputs 3..0
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.idx == '0) |=> en[3:0] == $past(wr.data[3:0]));

    // R7: a request beyond the bank leaves it untouched
    p_high_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.idx >= IDXW'(NUM_REGS)) |=> $stable(bank));

endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate #(
    parameter int N = 13
) (
    input  logic         ref_clk,
    input  logic [N-1:0] en,
    output logic [N-1:0] clk_out
);
    for (genvar g = 0; g < N; g++) begin : g_and
        assign clk_out[g] = ref_clk & en[g];
    end
endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
    import clkfan_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                ref_clk,
    output logic                sda_oe,
    output logic [NUM_OUTS-1:0] out_en,
    output logic [NUM_OUTS-1:0] clk_out
);
    logic [1:0]      clean;
    logic [7:0]      rd_data;
    logic [IDXW-1:0] rd_idx;
    wr_req_t         wr;

    clkfan_sync #(.W(2), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   ({scl_in, sda_in}),
        .clean (clean)
    );

    clkfan_serial u_serial (
        .clk     (clk),
        .rst     (rst),
        .scl_f   (clean[1]),
        .sda_f   (clean[0]),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    clkfan_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .en      (out_en)
    );

    clkfan_gate #(.N(NUM_OUTS)) u_gate (
        .ref_clk (ref_clk),
        .en      (out_en),
        .clk_out (clk_out)
    );

endmodule

// File: tb/clkfan_ctrl_bench.sv
`timescale 1ns/1ps
module clkfan_ctrl_bench;
    localparam int H = 16;

    logic clk = 1'b0, rst = 1'b1, ref_clk = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    logic [12:0] out_en, clk_out;
    int checks = 0, errors = 0, viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] txb [16];
    logic [7:0] rxb [16];

    // row: {byte0, byte1, byte2, expected enables}
    localparam logic [36:0] TBL [5] = '{
        {8'h00, 8'h00, 8'h00, 13'h0000},
        {8'h0F, 8'hF0, 8'h40, 13'h1F0F},
        {8'h30, 8'h0C, 8'hBF, 13'h0000},
        {8'hC5, 8'hA6, 8'hFF, 13'h1AB5},
        {8'hFF, 8'hFF, 8'hFF, 13'h1FFF}
    };

    always #2.5 clk = ~clk;
    always #7 ref_clk = ~ref_clk;
    assign sda_line = sda_m & ~sda_oe;

    clkfan_ctrl u_clkfan_ctrl (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .ref_clk(ref_clk),
        .sda_oe(sda_oe), .out_en(out_en), .clk_out(clk_out)
    );

    always @(posedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl_m) viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H);
        sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H / 2);
        ack = ~sda_line; hw(H / 2); scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw(H); scl_m = 1'b1; hw(H / 2);
            d = {d[6:0], sda_line}; hw(H / 2); scl_m = 1'b0;
        end
        sda_m = ~give_ack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
        hw(2); sda_m = 1'b1;
    endtask

    // write header plus n data bytes from txb, returns 1 if every byte was acknowledged
    task automatic do_write(input int n, output logic all_ack);
        logic a;
        bus_start();
        write_byte(8'hD2, a); all_ack = a;
        write_byte(8'h5A, a); all_ack &= a;
        write_byte(8'h03, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            write_byte(txb[i], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic do_read(input int n, output logic addr_ack);
        bus_start();
        write_byte(8'hD3, addr_ack);
        for (int i = 0; i < n; i++) read_byte(i != n - 1, rxb[i]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ok;
        logic [12:0] held;
        hw(10); rst = 1'b0; hw(10);

        // R4: reset state
        chk("R4 enables after reset", 32'(out_en), 32'h1FFF);
        chk("R4 sda released", 32'(sda_oe), 32'h0);

        // R3/R4/R10: readback after reset
        do_read(4, ok);
        chk("R1 read address acked", 32'(ok), 32'h1);
        chk("R3 length byte", 32'(rxb[0]), 32'h09);
        for (int i = 1; i < 4; i++) chk("R4 reset byte value", 32'(rxb[i]), 32'hFF);

        // R2/R5/R10: table of writes and readbacks
        for (int r = 0; r < 5; r++) begin
            txb[0] = TBL[r][36:29]; txb[1] = TBL[r][28:21]; txb[2] = TBL[r][20:13];
            do_write(3, ok);
            chk("R2 write acked", 32'(ok), 32'h1);
            chk("R5 enable mapping", 32'(out_en), 32'(TBL[r][12:0]));
            do_read(4, ok);
            chk("R3 length byte first", 32'(rxb[0]), 32'h09);
            for (int i = 0; i < 3; i++)
                chk("R10 readback incl spare bits", 32'(rxb[i + 1]), 32'(txb[i]));
        end

        // R1: foreign address ignored
        txb[0] = 8'h00; txb[1] = 8'h00; txb[2] = 8'h00;
        bus_start();
        write_byte(8'hA4, ok);
        chk("R1 foreign address not acked", 32'(ok), 32'h0);
        for (int i = 0; i < 5; i++) write_byte(8'h00, ok);
        bus_stop();
        chk("R1 foreign write no effect", 32'(out_en), 32'h1FFF);

        // R7: bytes beyond byte 2 acked and ignored
        txb[0] = 8'h12; txb[1] = 8'h34; txb[2] = 8'h56;
        txb[3] = 8'h00; txb[4] = 8'h00; txb[5] = 8'h00;
        do_write(6, ok);
        chk("R7 all bytes acked", 32'(ok), 32'h1);
        do_read(10, ok);
        chk("R7 byte0 kept", 32'(rxb[1]), 32'h12);
        chk("R7 byte1 kept", 32'(rxb[2]), 32'h34);
        chk("R7 byte2 kept", 32'(rxb[3]), 32'h56);
        for (int i = 4; i < 10; i++) chk("R3 high bytes read FF", 32'(rxb[i]), 32'hFF);

        // R8: NACK after length byte ends read
        bus_start();
        write_byte(8'hD3, ok);
        read_byte(1'b0, rxb[0]);
        hw(H);
        chk("R8 sda released after nack", 32'(sda_oe), 32'h0);
        chk("R8 length byte", 32'(rxb[0]), 32'h09);
        bus_stop();
        do_read(2, ok);
        chk("R8 next read restarts at length", 32'(rxb[0]), 32'h09);
        chk("R8 next read byte0", 32'(rxb[1]), 32'h12);

        // R9: repeated start during write, then read
        bus_start();
        write_byte(8'hD2, ok); write_byte(8'h00, ok); write_byte(8'h09, ok);
        write_byte(8'hE0, ok);
        bus_start();
        write_byte(8'hD3, ok);
        chk("R9 address after repeated start acked", 32'(ok), 32'h1);
        read_byte(1'b1, rxb[0]); read_byte(1'b0, rxb[1]);
        bus_stop();
        chk("R9 length after restart", 32'(rxb[0]), 32'h09);
        chk("R9 byte0 stored before restart", 32'(rxb[1]), 32'hE0);

        // R9: stop inside a byte stores nothing
        held = out_en;
        bus_start();
        write_byte(8'hD2, ok); write_byte(8'h00, ok); write_byte(8'h09, ok);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        hw(4 * H);
        chk("R9 partial byte not stored", 32'(out_en), 32'(held));

        // R6: gating with a mixed enable pattern
        txb[0] = 8'h0F; txb[1] = 8'hF0; txb[2] = 8'h40;
        do_write(3, ok);
        for (int i = 0; i < 20; i++) begin
            hw(3);
            chk("R6 gated clock", 32'(clk_out), 32'({13{ref_clk}} & 13'h1F0F));
        end

        chk("R11 drive changes while SCL high", viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule